// File: doc/BRIEF.md
# Constant-time clearable memory

A word-addressable memory of `N` entries whose entire contents can be wiped to zero in one clock cycle, however deep the memory is. No location is rewritten by a wipe. Instead the block tracks which units hold live data with a sparse set: a slot array maps each unit to a position, an owner array maps each position back to a unit, and a fill counter says how many positions are live. A unit counts as written only when its slot is below the fill count and the owner at that slot names the unit. A wipe only zeroes the fill counter.

None of the three arrays is ever reset. Whatever stale or random contents they hold, the two-way check rejects them, so a unit that was never written since the last wipe always reads back as zero with its valid flag low. The block has one write port, one read port with one cycle of latency, a wipe pulse and a fill-count output. Typical uses are lookup tables and marker bitmaps that must start empty on every pass of a real-time loop, where a clear that scales with depth cannot be afforded.

Top module: `clrmem_top`

## Requirements
- R1: After reset, `fill_count` is 0 and the read port returns `rd_valid` = 0 with `rd_data` = 0, whatever the arrays hold.
- R2: A read samples `rd_addr` at a rising edge and presents the result after that edge. For a unit written since the last wipe, it returns the latest written word with `rd_valid` = 1.
- R3: The first write to a unit since the last wipe raises `fill_count` by exactly 1. A cycle with neither write nor wipe leaves it unchanged. It never exceeds `N`.
- R4: A write to a unit that is already live replaces its data word and leaves `fill_count` unchanged.
- R5: A read of a unit not written since the last wipe (or since reset) returns `rd_data` = 0 and `rd_valid` = 0.
- R6: A pulse on `clr` empties the memory in that single edge. `fill_count` becomes 0 and every unit then reads as in R5, regardless of how many units were live.
- R7: After a wipe, a unit whose stale slot lies below the new fill count is still reported as not written when the owner at that slot names a different unit.
- R8: When `clr` and `wr_en` are high in the same cycle, the wipe acts first. The written unit becomes the only live unit, and `fill_count` is 1.
- R9: A read in the same cycle as a write or a wipe returns the memory state from before that edge.
- R10: Writing all `N` distinct units brings `fill_count` to `N`, and every unit then reads back valid with its own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the fill counter and read register |
| clr | input | 1 | Wipe pulse: empties the memory in one cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Unit written |
| wr_data | input | W | Word written |
| rd_addr | input | AW | Unit read |
| rd_data | output | W | Read word, zero for a unit not written |
| rd_valid | output | 1 | High when the unit read had been written since the last wipe |
| fill_count | output | CW | Number of live units, 0 to N |

## Verification
The main function is driven in several ways. A full fill in shuffled order with scattered reads shows that every unit can hold its own data up to `N` live entries. Rewrites of live units separate a data update from a fresh push. A wipe after a full fill leaves every slot and owner entry stale yet still self-consistent. Writing one unit after that wipe puts a stale slot in range, and a read of the unit that first owned position 0 shows whether the owner comparison is really applied. A long random mix with rare wipes, wipe-with-write cycles and reads on the address just written covers ordering at a shared edge against a fully zeroed model.

// File: rtl/clrmem_pkg.sv
package clrmem_pkg;
   // Width of a counter that must hold every value from 0 to n inclusive.
   function automatic int cnt_w(input int n);
      return $clog2(n + 1);
   endfunction

   // Width of an index that must name n distinct entries (at least 1 bit).
   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/clrmem_store.sv
// Unreset storage array: one synchronous write port, NRD combinational read ports.
module clrmem_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 16,
   parameter int AW    = 6,
   parameter int NRD   = 1
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic [AW-1:0]         waddr,
   input  logic [WIDTH-1:0]      wdata,
   input  logic [NRD*AW-1:0]     raddr,
   output logic [NRD*WIDTH-1:0]  rdata
);
   localparam bit FULL = (DEPTH == (1 << AW));

   if (DEPTH < 1 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("clrmem_store: DEPTH does not fit in AW bits");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("clrmem_store: NRD must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   if (FULL) begin : g_wr_full
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end
   end else begin : g_wr_part
      always_ff @(posedge clk) begin
         if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [AW-1:0] a;
      assign a = raddr[p*AW +: AW];
      if (FULL) begin : g_full
         assign rdata[p*WIDTH +: WIDTH] = mem[a];
      end else begin : g_part
         assign rdata[p*WIDTH +: WIDTH] =
            ({1'b0, a} < (AW+1)'(DEPTH)) ? mem[a] : '0;
      end
   end
endmodule

// File: rtl/clrmem_probe.sv
// Membership test of the sparse set: slot below fill and owner names the unit.
module clrmem_probe #(
   parameter int AW = 6,
   parameter int CW = 7
) (
   input  logic [AW-1:0] unit,
   input  logic [AW-1:0] slot,
   input  logic [AW-1:0] owner,
   input  logic [CW-1:0] fill,
   output logic          hit
);
   if (CW < AW) begin : g_bad_w
      $error("clrmem_probe: CW must not be narrower than AW");
   end

   logic in_range;
   assign in_range = (CW'(slot) < fill);
   assign hit      = in_range && (owner == unit);
endmodule

// File: rtl/clrmem_fill.sv
// Fill counter: a wipe zeroes it before any push of the same cycle.
module clrmem_fill #(
   parameter int N  = 64,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_eff
);
   if ((1 << CW) <= N) begin : g_bad_cw
      $error("clrmem_fill: CW too narrow for N");
   end

   assign count_eff = clr ? '0 : count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (push) count <= count_eff + CW'(1);
      else           count <= count_eff;
   end
endmodule

// File: rtl/clrmem_top.sv
module clrmem_top #(
   parameter  int N  = 64,
   parameter  int W  = 16,
   localparam int AW = clrmem_pkg::idx_w(N),
   localparam int CW = clrmem_pkg::cnt_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data,
   output logic          rd_valid,
   output logic [CW-1:0] fill_count
);
   if (N < 2) begin : g_bad_n
      $error("clrmem_top: N must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("clrmem_top: W must be at least 1");
   end

   logic [CW-1:0] count, count_eff;
   logic          push;
   logic [AW-1:0] slot_rd, slot_wr, owner_rd, owner_wr;
   logic [W-1:0]  word_rd;
   logic          hit_rd, hit_wr;

   // Slot array: unit -> position. Port 0 serves the reader, port 1 the writer.
   clrmem_store #(.DEPTH(N), .WIDTH(AW), .AW(AW), .NRD(2)) u_slot (
      .clk   (clk),
      .we    (push),
      .waddr (wr_addr),
      .wdata (count_eff[AW-1:0]),
      .raddr ({wr_addr, rd_addr}),
      .rdata ({slot_wr, slot_rd})
   );

   // Owner array: position -> unit.
   clrmem_store #(.DEPTH(N), .WIDTH(AW), .AW(AW), .NRD(2)) u_owner (
      .clk   (clk),
      .we    (push),
      .waddr (count_eff[AW-1:0]),
      .wdata (wr_addr),
      .raddr ({slot_wr, slot_rd}),
      .rdata ({owner_wr, owner_rd})
   );

   // Data words.
   clrmem_store #(.DEPTH(N), .WIDTH(W), .AW(AW), .NRD(1)) u_data (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (word_rd)
   );

   // Reader tests against the pre-edge count; writer against the wipe-aware one.
   clrmem_probe #(.AW(AW), .CW(CW)) u_probe_rd (
      .unit (rd_addr), .slot (slot_rd), .owner (owner_rd),
      .fill (count), .hit (hit_rd)
   );
   clrmem_probe #(.AW(AW), .CW(CW)) u_probe_wr (
      .unit (wr_addr), .slot (slot_wr), .owner (owner_wr),
      .fill (count_eff), .hit (hit_wr)
   );

   assign push = wr_en && !hit_wr;

   clrmem_fill #(.N(N), .CW(CW)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (push),
      .count     (count),
      .count_eff (count_eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= hit_rd;
         rd_data  <= hit_rd ? word_rd : '0;
      end
   end

   assign fill_count = count;
endmodule

// File: rtl/clrmem_chk.sv
module clrmem_chk #(
   parameter int N  = 64,
   parameter int W  = 16,
   parameter int AW = 6,
   parameter int CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [W-1:0]  wr_data,
   input logic [AW-1:0] rd_addr,
   input logic [W-1:0]  rd_data,
   input logic          rd_valid,
   input logic [CW-1:0] fill_count
);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(N));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !wr_en) |=> $stable(fill_count));

   assert_wipe_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fill_count == CW'($past(wr_en))));

   assert_wipe_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> ##1 !rd_valid);

   assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   assert_write_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && (rd_addr == $past(wr_addr)))
         |=> (rd_valid && (rd_data == $past(wr_data, 2))));
endmodule

bind clrmem_top clrmem_chk #(.N(N), .W(W), .AW(AW), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .fill_count (fill_count)
);

// File: tb/clrmem_top_tb.sv
`timescale 1ns/1ps
module clrmem_top_tb;
   localparam int N  = 64;
   localparam int W  = 16;
   localparam int AW = 6;
   localparam int CW = 7;
   localparam int LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic          rd_valid;
   logic [CW-1:0] fill_count;

   always #10 clk = ~clk;

   clrmem_top #(.N(N), .W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .fill_count(fill_count)
   );

   // Reference model, zeroed in full.
   logic [W-1:0] m_data [N];
   bit           m_live [N];
   int           m_cnt;
   bit           pend;
   bit           p_valid;
   logic [W-1:0] p_data;
   string        p_tag;
   int           vectors = 0, errs = 0;
   bit           done = 1'b0;
   int           perm [N];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_wipe();
      for (int i = 0; i < N; i++) begin m_live[i] = 1'b0; m_data[i] = '0; end
      m_cnt = 0;
   endtask

   task automatic check_out();
      if (pend) begin
         chk(rd_valid == p_valid, p_tag, "rd_valid", rd_valid, p_valid);
         chk(rd_data == p_data, p_tag, "rd_data", rd_data, p_data);
         chk(fill_count == CW'(m_cnt), p_tag, "fill_count", fill_count, m_cnt);
      end
   endtask

   // One cycle: check the previous result, drive, predict, update the model.
   task automatic cyc(input bit c, input bit we, input int a, input logic [W-1:0] d,
                      input int ra, input string tag);
      @(negedge clk);
      check_out();
      clr = c; wr_en = we; wr_addr = AW'(a); wr_data = d; rd_addr = AW'(ra);
      p_valid = m_live[ra];                         // R9: pre-edge state
      p_data  = m_live[ra] ? m_data[ra] : '0;
      p_tag   = tag;
      pend    = 1'b1;
      if (c) model_wipe();
      if (we) begin
         if (!m_live[a]) m_cnt++;
         m_live[a] = 1'b1;
         m_data[a] = d;
      end
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         errs++;
         vectors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_wipe();
      pend = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(fill_count == '0, "R1", "fill_count", fill_count, 0);
      chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
      chk(rd_data == '0, "R1", "rd_data", rd_data, 0);
      rst_n = 1'b1;

      // R5: reads before any write
      for (int i = 0; i < 8; i++) cyc(0, 0, 0, '0, i * 7, "R5");

      // R10/R2/R3: fill every unit in shuffled order
      for (int i = 0; i < N; i++) perm[i] = i;
      for (int i = N - 1; i > 0; i--) begin
         int j = $urandom_range(i, 0);
         int t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < N; i++)
         cyc(0, 1, perm[i], W'($urandom), $urandom_range(N - 1, 0), "R3");
      for (int i = 0; i < N; i++) cyc(0, 0, 0, '0, i, "R10");

      // R4: rewrite live units
      for (int i = 0; i < 10; i++) begin
         int u = $urandom_range(N - 1, 0);
         cyc(0, 1, u, W'($urandom), u, "R4");
         cyc(0, 0, 0, '0, u, "R4");
      end

      // R9: read the unit written at the same edge
      cyc(0, 1, 5, 16'hBEEF, 5, "R9");
      cyc(0, 0, 0, '0, 5, "R9");

      // R6: wipe a full memory, then every unit reads empty
      cyc(1, 0, 0, '0, 3, "R9");
      for (int i = 0; i < N; i++) cyc(0, 0, 0, '0, i, "R6");

      // R7: stale slot 0 of perm[0] back in range, owner now names another unit
      cyc(0, 1, perm[5], 16'h1234, perm[0], "R7");
      cyc(0, 0, 0, '0, perm[0], "R7");
      cyc(0, 0, 0, '0, perm[5], "R7");

      // R8: wipe and write in one cycle
      cyc(0, 1, perm[9], 16'h0F0F, 0, "R8");
      cyc(1, 1, perm[1], 16'hA5A5, perm[1], "R8");
      cyc(0, 0, 0, '0, perm[1], "R8");
      cyc(0, 0, 0, '0, perm[9], "R8");
      cyc(0, 0, 0, '0, perm[5], "R8");

      // Random mix, rare wipes
      for (int i = 0; i < 3000; i++) begin
         bit c  = ($urandom_range(99, 0) < 2);
         bit we = ($urandom_range(99, 0) < 55);
         int a  = $urandom_range(N - 1, 0);
         int ra = ($urandom_range(3, 0) == 0) ? a : $urandom_range(N - 1, 0);
         cyc(c, we, a, W'($urandom), ra, "R2");
      end
      cyc(0, 0, 0, '0, 0, "R2");
      @(negedge clk);
      check_out();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule